// File: doc/BRIEF.md
# Cartridge Bank Controller

The block watches CPU writes that land in the lower half of the 16-bit address space (0x0000 to 0x7FFF). Such writes never reach memory. The controller treats each one as a command, taking both the address and the data into account. From these commands it keeps three pieces of state: a ROM bank number, an external-RAM bank number and a RAM enable flag. All three go straight to the address decoder that builds the physical ROM and RAM addresses.

A static mode input picks one of five command layouts:

| Code | Mode | Behaviour |
|------|------|-----------|
| 0 | flat | No banking at all |
| 1 | split | 5-bit low bank field plus a shared 2-bit upper field |
| 2 | address-bit | Decodes on address bit 8 instead of on address windows |
| 3 | wide-7 | 7-bit ROM bank |
| 4 | wide-9 | 9-bit ROM bank written through two registers |

Codes 5 to 7 behave as flat.

Two static inputs give the fitted ROM and RAM sizes as base-2 logarithms of the bank count. After every command write, both bank numbers are trimmed so they never point past the fitted memory.

Top module: `cart_bank_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs become ROM bank 1, RAM bank 0 and RAM disabled.
- R2: In modes 1, 3 and 4, a write to 0x0000-0x1FFF updates the RAM enable. It sets `ram_en` to 1 when `wr_data[3:0]` is 0xA, and to 0 for any other value.
- R3: In mode 1, a write to 0x2000-0x3FFF takes `wr_data[4:0]` and turns 0 into 1. The result replaces ROM bank bits 4:0, bits 6:5 keep their value, and bits 8:7 become 0.
- R4: In mode 1, a write to 0x4000-0x5FFF sets the RAM bank to `wr_data[1:0]` and also copies `wr_data[1:0]` into ROM bank bits 6:5.
- R5: Mode 2 decodes on address bit 8.
  - A write to 0x0000-0x7FFF with address bit 8 clear updates the RAM enable as in R2.
  - A write with address bits 15:13 = 001 and bit 8 set loads the ROM bank with `wr_data[3:0]`, with no zero remap.
  - All other writes change nothing.
- R6: In mode 3, a write to 0x2000-0x3FFF loads the ROM bank with `wr_data[6:0]`, with 0 turned into 1. A write to 0x4000-0x5FFF loads the RAM bank with `wr_data[1:0]`.
- R7: Mode 4 uses three write windows.
  - A write to 0x2000-0x2FFF replaces ROM bank bits 7:0 with `wr_data`, with 0 turned into 1, and keeps bit 8.
  - A write to 0x3000-0x3FFF sets ROM bank bit 8 to `wr_data[0]`.
  - A write to 0x4000-0x5FFF loads the RAM bank with `wr_data[3:0]`.
- R8: In modes 1 to 4, every write to 0x0000-0x7FFF finishes by ANDing the ROM bank with 2^`rom_size_log2`-1 and the RAM bank with 2^`ram_size_log2`-1. The zero remap happens before this AND.
- R9: In modes 1 to 4, the following leave the state unchanged apart from the R8 masking:
  - writes to 0x6000-0x7FFF;
  - writes with address bit 15 set;
  - cycles with `wr_en` low.
- R10: In mode 0 and codes 5 to 7, no write changes any output.
- R11: Every output changes on the clock edge that samples the command write, so the new value is visible in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 3 | Static controller mode (0 flat, 1 split, 2 address-bit, 3 wide-7, 4 wide-9) |
| rom_size_log2 | input | 4 | Static log2 of the fitted ROM bank count |
| ram_size_log2 | input | 3 | Static log2 of the fitted RAM bank count |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| rom_bank | output | 9 | Current ROM bank number |
| ram_bank | output | 4 | Current RAM bank number |
| ram_en | output | 1 | External RAM enable |

## Verification
The bench keeps the default widths: a 9-bit ROM bank and a 4-bit RAM bank. This makes the bit-8 register of mode 4 and the full 4-bit RAM field reachable. Between resets it changes the size inputs, running from the full 512/16 banks down to 4/2 and to a single bank. That brings the masking corners within reach: a remapped 0 is trimmed back to 0, a bank just past the fitted size wraps, and a pure mask-only write to 0x6000 clears the reset value of bank 1. Every mode, including the unused codes, is driven with directed commands and a stream of pseudo-random writes.

// File: rtl/cbc_pkg.sv
// Package for the cartridge bank controller.
// Holds the field widths, the mode encoding and the bank state record.
// Assumes the ROM bank field is at least 9 bits wide and the RAM field at least 4 bits wide.
package cbc_pkg;
    localparam int ROM_BW = 9;
    localparam int RAM_BW = 4;
    localparam int ROM_LW = $clog2(ROM_BW + 1);
    localparam int RAM_LW = $clog2(RAM_BW + 1);

    typedef enum logic [2:0] {
        MODE_FLAT   = 3'd0,
        MODE_SPLIT5 = 3'd1,
        MODE_ABIT   = 3'd2,
        MODE_WIDE7  = 3'd3,
        MODE_WIDE9  = 3'd4
    } cbc_mode_e;

    typedef struct packed {
        logic [ROM_BW-1:0] rom;
        logic [RAM_BW-1:0] ram;
        logic              en;
    } cbc_state_t;

    localparam cbc_state_t RESET_STATE = '{rom: ROM_BW'(1), ram: '0, en: 1'b0};
endpackage

// File: rtl/cbc_cmd_decode.sv
// Command decoder.
// Turns one CPU write into the next bank state, before masking.
// Assumes mode_sel is static; unknown codes behave as flat.
// cmd_hit flags a write that must be loaded, and then masked.
module cbc_cmd_decode
    import cbc_pkg::*;
(
    input  logic [2:0]  mode_sel,
    input  logic        wr_en,
    input  logic [15:0] wr_addr,
    input  logic [7:0]  wr_data,
    input  cbc_state_t  cur,
    output cbc_state_t  nxt,
    output logic        cmd_hit
);
    logic [1:0] window;
    logic       lo_half;
    logic       en_val;
    logic [4:0] lo5;
    logic [6:0] lo7;
    logic [7:0] lo8;

    // Shared operand preparation: write window, enable value, zero-remapped fields.
    always_comb begin
        window  = wr_addr[14:13];
        lo_half = wr_en && !wr_addr[15];
        en_val  = (wr_data[3:0] == 4'hA);
        lo5     = (wr_data[4:0] == 5'd0) ? 5'd1 : wr_data[4:0];
        lo7     = (wr_data[6:0] == 7'd0) ? 7'd1 : wr_data[6:0];
        lo8     = (wr_data == 8'd0) ? 8'd1 : wr_data;
    end

    // Per-mode command decode.
    always_comb begin
        nxt     = cur;
        cmd_hit = 1'b0;
        case (mode_sel)
            MODE_SPLIT5: begin
                cmd_hit = lo_half;
                case (window)
                    2'd0: nxt.en = en_val;
                    2'd1: nxt.rom = {2'b00, cur.rom[6:5], lo5};
                    2'd2: begin
                        nxt.ram = {2'b00, wr_data[1:0]};
                        nxt.rom = {2'b00, wr_data[1:0], cur.rom[4:0]};
                    end
                    default: ;
                endcase
            end
            MODE_ABIT: begin
                cmd_hit = lo_half;
                if (!wr_addr[8])
                    nxt.en = en_val;
                else if (wr_addr[15:13] == 3'b001)
                    nxt.rom = {5'd0, wr_data[3:0]};
            end
            MODE_WIDE7: begin
                cmd_hit = lo_half;
                case (window)
                    2'd0: nxt.en = en_val;
                    2'd1: nxt.rom = {2'b00, lo7};
                    2'd2: nxt.ram = {2'b00, wr_data[1:0]};
                    default: ;
                endcase
            end
            MODE_WIDE9: begin
                cmd_hit = lo_half;
                case (window)
                    2'd0: nxt.en = en_val;
                    2'd1: begin
                        if (!wr_addr[12])
                            nxt.rom = {cur.rom[8], lo8};
                        else
                            nxt.rom = {wr_data[0], cur.rom[7:0]};
                    end
                    2'd2: nxt.ram = wr_data[3:0];
                    default: ;
                endcase
            end
            default: cmd_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/cbc_bank_mask.sv
// Size mask.
// Keeps bit i of a bank number only when i < lg, where lg is the log2 of the bank count.
// Assumes lg is static; any lg >= W keeps every bit.
module cbc_bank_mask #(
    parameter int W  = 9,
    parameter int LW = 4
) (
    input  logic [W-1:0]  bank_in,
    input  logic [LW-1:0] lg,
    output logic [W-1:0]  bank_out
);
    // One gate per bit: the bit survives when its index is below the size exponent.
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bank_out[i] = bank_in[i] & (32'(lg) > i);
    end
endmodule

// File: rtl/cbc_state_reg.sv
// Bank state register.
// Loads a new state record on a command write.
// Assumes a synchronous active-low reset that returns the reset record.
module cbc_state_reg
    import cbc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  cbc_state_t d,
    output cbc_state_t q
);
    // Hold the bank state; reset wins, otherwise load on a command write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= RESET_STATE;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/cart_bank_ctrl.sv
// Cartridge bank controller top.
// Decodes CPU writes below 0x8000 into ROM bank, RAM bank and RAM enable.
// Masks both bank numbers to the fitted sizes.
// Assumes mode_sel and the size inputs change only while rst_n is low.
module cart_bank_ctrl
    import cbc_pkg::*;
#(
    parameter int ROM_W  = ROM_BW,
    parameter int RAM_W  = RAM_BW,
    parameter int ROM_LG = ROM_LW,
    parameter int RAM_LG = RAM_LW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_sel,
    input  logic [ROM_LG-1:0] rom_size_log2,
    input  logic [RAM_LG-1:0] ram_size_log2,
    input  logic              wr_en,
    input  logic [15:0]       wr_addr,
    input  logic [7:0]        wr_data,
    output logic [ROM_W-1:0]  rom_bank,
    output logic [RAM_W-1:0]  ram_bank,
    output logic              ram_en
);
    cbc_state_t cur_q;
    cbc_state_t dec_nxt;
    cbc_state_t msk_nxt;
    logic       hit;

    cbc_cmd_decode u_dec (
        .mode_sel (mode_sel),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .cur      (cur_q),
        .nxt      (dec_nxt),
        .cmd_hit  (hit)
    );

    cbc_bank_mask #(.W(ROM_W), .LW(ROM_LG)) u_rom_mask (
        .bank_in  (dec_nxt.rom),
        .lg       (rom_size_log2),
        .bank_out (msk_nxt.rom)
    );

    cbc_bank_mask #(.W(RAM_W), .LW(RAM_LG)) u_ram_mask (
        .bank_in  (dec_nxt.ram),
        .lg       (ram_size_log2),
        .bank_out (msk_nxt.ram)
    );

    // The enable flag bypasses masking.
    assign msk_nxt.en = dec_nxt.en;

    cbc_state_reg u_state (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (hit),
        .d     (msk_nxt),
        .q     (cur_q)
    );

    // Drive the decoder-facing outputs from the held state.
    assign rom_bank = cur_q.rom;
    assign ram_bank = cur_q.ram;
    assign ram_en   = cur_q.en;
endmodule

// File: rtl/cbc_chk.sv
// Property checker for cart_bank_ctrl.
// Observes the ports only, and is bound into every instance of the top.
module cbc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  mode_sel,
    input logic [3:0]  rom_size_log2,
    input logic [2:0]  ram_size_log2,
    input logic        wr_en,
    input logic [15:0] wr_addr,
    input logic [7:0]  wr_data,
    input logic [8:0]  rom_bank,
    input logic [3:0]  ram_bank,
    input logic        ram_en
);
    logic [31:0] rom_lim;
    logic [31:0] ram_lim;
    logic        banked;

    // Independent size limits and banked-mode flag.
    always_comb begin
        rom_lim = (32'd1 << rom_size_log2) - 32'd1;
        ram_lim = (32'd1 << ram_size_log2) - 32'd1;
        banked  = (mode_sel >= 3'd1) && (mode_sel <= 3'd4);
    end

    // R1
    reset_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rom_bank == 9'd1 && ram_bank == 4'd0 && !ram_en));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_en)));

    // R10
    flat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !banked |=> ($stable(rom_bank) && $stable(ram_bank) && $stable(ram_en)));

    // R8
    size_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr[15] && banked) |=>
            ((32'(rom_bank) & ~rom_lim) == 32'd0 && (32'(ram_bank) & ~ram_lim) == 32'd0));

    // R2
    ram_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15:13] == 3'b000 && banked && mode_sel != 3'd2) |=>
            (ram_en == ($past(wr_data[3:0]) == 4'hA)));

    // R6
    zero_remap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && mode_sel == 3'd3 && wr_addr[15:13] == 3'b001 &&
         wr_data[6:0] == 7'd0 && rom_size_log2 != 4'd0) |=> (rom_bank == 9'd1));
endmodule

bind cart_bank_ctrl cbc_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mode_sel      (mode_sel),
    .rom_size_log2 (rom_size_log2),
    .ram_size_log2 (ram_size_log2),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .rom_bank      (rom_bank),
    .ram_bank      (ram_bank),
    .ram_en        (ram_en)
);

// File: tb/sim_cart_bank_ctrl.sv
`timescale 1ns/1ps
module sim_cart_bank_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_sel = 3'd0;
    logic [3:0]  rom_size_log2 = 4'd9;
    logic [2:0]  ram_size_log2 = 3'd4;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = 16'd0;
    logic [7:0]  wr_data = 8'd0;
    logic [8:0]  rom_bank;
    logic [3:0]  ram_bank;
    logic        ram_en;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state.
    int m_rom;
    int m_ram;
    int m_en;

    always #2.5 clk = ~clk;

    cart_bank_ctrl u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_sel      (mode_sel),
        .rom_size_log2 (rom_size_log2),
        .ram_size_log2 (ram_size_log2),
        .wr_en         (wr_en),
        .wr_addr       (wr_addr),
        .wr_data       (wr_data),
        .rom_bank      (rom_bank),
        .ram_bank      (ram_bank),
        .ram_en        (ram_en)
    );

    task automatic model(input logic we, input int a, input int d);
        int v;
        if (we && a < 'h8000 && mode_sel >= 3'd1 && mode_sel <= 3'd4) begin
            case (mode_sel)
                3'd1: begin
                    if (a < 'h2000) m_en = ((d & 15) == 10);
                    else if (a < 'h4000) begin
                        v = d & 31; if (v == 0) v = 1;
                        m_rom = (m_rom & 'h60) | v;
                    end else if (a < 'h6000) begin
                        m_ram = d & 3;
                        m_rom = (m_rom & 'h1F) | ((d & 3) << 5);
                    end
                end
                3'd2: begin
                    if ((a & 'h100) == 0) m_en = ((d & 15) == 10);
                    else if ((a & 'hE100) == 'h2100) m_rom = d & 15;
                end
                3'd3: begin
                    if (a < 'h2000) m_en = ((d & 15) == 10);
                    else if (a < 'h4000) begin
                        v = d & 127; if (v == 0) v = 1;
                        m_rom = v;
                    end else if (a < 'h6000) m_ram = d & 3;
                end
                default: begin
                    if (a < 'h2000) m_en = ((d & 15) == 10);
                    else if (a < 'h3000) begin
                        v = d & 255; if (v == 0) v = 1;
                        m_rom = (m_rom & 'h100) | v;
                    end else if (a < 'h4000) m_rom = (m_rom & 'hFF) | ((d & 1) << 8);
                    else if (a < 'h6000) m_ram = d & 15;
                end
            endcase
            m_rom = m_rom & ((1 << rom_size_log2) - 1);
            m_ram = m_ram & ((1 << ram_size_log2) - 1);
        end
    endtask

    task automatic check(input string tag);
        n_chk++;
        if (int'(rom_bank) != m_rom || int'(ram_bank) != m_ram || int'(ram_en) != m_en) begin
            n_fail++;
            $display("FAIL %s: rom=%0h ram=%0h en=%0d expected rom=%0h ram=%0h en=%0d",
                     tag, rom_bank, ram_bank, ram_en, m_rom, m_ram, m_en);
        end
    endtask

    // Drive one cycle at a falling edge, advance the model, compare on the next falling edge.
    task automatic step(input logic we, input int a, input int d, input string tag);
        wr_en = we; wr_addr = 16'(a); wr_data = 8'(d);
        @(negedge clk);
        model(we, a, d);
        check(tag);
    endtask

    task automatic do_reset(input int md, input int rl, input int ml);
        rst_n = 1'b0; wr_en = 1'b0;
        mode_sel = 3'(md); rom_size_log2 = 4'(rl); ram_size_log2 = 3'(ml);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        m_rom = 1; m_ram = 0; m_en = 0;
        check("R1");
    endtask

    task automatic rand_run(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            int a;
            a = int'($urandom & 32'hFFFF);
            if (i % 4 != 0) a = a & 'h7FFF;
            step((i % 7) != 3, a, int'($urandom & 32'hFF), tag);
        end
    endtask

    initial begin
        @(negedge clk);
        // Mode 1, split register layout.
        do_reset(1, 9, 4);
        step(1, 'h0000, 'h0A, "R2");
        step(1, 'h1000, 'h1A, "R2");
        step(1, 'h0000, 'h0B, "R2");
        step(1, 'h2000, 'h00, "R3");
        step(1, 'h2100, 'h13, "R3");
        step(1, 'h4000, 'h03, "R4");
        step(1, 'h2000, 'hE0, "R3");
        step(1, 'h6000, 'h01, "R9");
        step(1, 'h8000, 'h0A, "R9");
        step(0, 'h2000, 'h05, "R11");
        rand_run(300, "R8");
        // Mode 2, address bit 8 decode.
        do_reset(2, 9, 4);
        step(1, 'h0000, 'h0A, "R5");
        step(1, 'h0100, 'h05, "R5");
        step(1, 'h2100, 'h00, "R5");
        step(1, 'h2100, 'hFF, "R5");
        step(1, 'h2000, 'h0A, "R5");
        step(1, 'h4000, 'h03, "R5");
        step(1, 'h6100, 'h07, "R5");
        rand_run(300, "R8");
        // Mode 3, wide 7-bit bank.
        do_reset(3, 9, 4);
        step(1, 'h2000, 'h80, "R6");
        step(1, 'h3FFF, 'h7F, "R6");
        step(1, 'h5000, 'hFF, "R6");
        step(1, 'h0000, 'h5A, "R2");
        rand_run(300, "R8");
        // Mode 4, 9-bit bank through two registers.
        do_reset(4, 9, 4);
        step(1, 'h2000, 'h00, "R7");
        step(1, 'h3000, 'h01, "R7");
        step(1, 'h2000, 'h00, "R7");
        step(1, 'h2FFF, 'h42, "R7");
        step(1, 'h3000, 'h00, "R7");
        step(1, 'h4000, 'h0F, "R7");
        rand_run(300, "R8");
        // Size masking corners.
        do_reset(3, 2, 1);
        step(1, 'h2000, 'h07, "R8");
        step(1, 'h2000, 'h04, "R8");
        step(1, 'h4000, 'h03, "R8");
        do_reset(1, 0, 0);
        step(1, 'h6000, 'h00, "R8");
        step(1, 'h2000, 'h00, "R8");
        do_reset(4, 5, 2);
        rand_run(200, "R8");
        // Flat and unused codes.
        do_reset(0, 9, 4);
        rand_run(150, "R10");
        do_reset(6, 9, 4);
        rand_run(150, "R10");
        wr_en = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule